// File: doc/BRIEF.md
# Half-Duplex Byte-Serial Host Access Port (Mode 0 Slave)

This block is the serial front end through which an external host reaches on-chip registers. The host drives a serial clock, an active-low select and a data-in line. The port oversamples all three with the faster system clock, rebuilds bytes most-significant bit first and hands each complete byte to on-chip logic with a one-cycle strobe. A flag marks the first byte of each select window. The on-chip command decoder can switch the open transaction into read mode. From then on the port shifts supplied bytes back out on the data-out pin, asks for each next byte with a load strobe and ignores data-in.

The output line is meant for a tri-state pad and is enabled only while read data is being shifted out. The select window is handled by a three-state machine:
- `ST_IDLE`: the select is high.
- `ST_RECV`: the select is low and bytes are being received.
- `ST_SEND`: read data is being shifted out.

The machine has these transitions:
- `ST_IDLE` to `ST_RECV` when the select is seen low.
- `ST_RECV` to `ST_SEND` when a read request arrives at a byte boundary.
- `ST_RECV` to `ST_IDLE` and `ST_SEND` to `ST_IDLE` when the select is seen high.

The system clock must run at least four times faster than the serial clock.

Top module: `spi_hd_slave`

## Requirements
- R1: Data-in is sampled on rising serial-clock edges. Each group of 8 rising edges while the select is low in receive mode yields `rx_data` holding those bits, the first-sampled bit at bit 7.
- R2: Several bytes may follow one another within one select-low window. `rx_first` is 1 with the strobe of the first byte after the select falls and 0 for every later byte of that window.
- R3: A byte left incomplete when the select rises is discarded with no strobe, and the next window starts a fresh byte.
- R4: `rx_valid` is high for exactly one system-clock cycle per received byte.
- R5: `rd_req` with `rd_data` is accepted only while the select is low (in receive mode, between bytes). Once accepted, `so_oe` rises and bit 7 of `rd_data` appears on `so` before the next rising serial-clock edge. With the select high, `rd_req` has no effect and `so_oe` stays 0.
- R6: In read mode, `so` changes only after falling serial-clock edges, so the host reads each byte most-significant bit first on its rising edges.
- R7: After the 8th rising edge of every read byte, `tx_load` pulses for one cycle. A `tx_wr` with `tx_wdata` before the following falling edge supplies the next read byte.
- R8: If no `tx_wr` arrives after a `tx_load`, the next read byte sent is 0x00.
- R9: In read mode, data-in is ignored and `rx_valid` stays 0.
- R10: `so_oe` is 0 outside read mode. When the select rises, read mode is left and `so_oe` falls within one system-clock cycle of the synchronized rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host, idles low |
| cs_n | input | 1 | Active-low select from host |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data to host (0 when not enabled) |
| so_oe | output | 1 | Output enable for the `so` pad |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_first | output | 1 | Marks the first byte of a select window |
| rd_req | input | 1 | Switch the current transaction to read mode |
| rd_data | input | DATA_W | First read byte, taken with `rd_req` |
| tx_load | output | 1 | One-cycle request for the next read byte |
| tx_wr | input | 1 | Strobe supplying the next read byte |
| tx_wdata | input | DATA_W | Next read byte |

## Verification
The hardest situation to reach is the hand-off into read mode. The read request has to land in the short gap between the command byte's last rising edge and the next one. The falling edge that follows the command byte must then be ignored rather than shift the fresh byte. The bench gets there by acting as the command decoder: it answers a received first byte that has bit 7 set with a read request on the very next cycle. It answers each load strobe at once, or withholds the answer for randomly chosen bytes. Transactions of random length, partial final bytes and directed cases check the first output bit before the first edge, 0x00 fill bytes and dropped partial bytes.

// File: rtl/spi_hd_pkg.sv
package spi_hd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_SEND = 2'd2
    } spi_state_e;
endpackage

// File: rtl/spi_hd_sync.sv
module spi_hd_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/spi_hd_rx.sv
module spi_hd_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              last_bit,
    input  logic              first_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_first
);
    logic [DATA_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q     <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_first <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_first <= 1'b0;
            if (shift_en) begin
                sr_q <= {sr_q[DATA_W-2:0], bit_in};
                if (last_bit) begin
                    rx_data  <= {sr_q[DATA_W-2:0], bit_in};
                    rx_valid <= 1'b1;
                    rx_first <= first_in;
                end
            end
        end
    end
endmodule

// File: rtl/spi_hd_tx.sv
module spi_hd_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              start,
    input  logic [DATA_W-1:0] start_data,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              adv,
    input  logic              reload,
    output logic              tx_bit
);
    logic [DATA_W-1:0] sr_q;
    logic [DATA_W-1:0] pend_q;
    logic              pend_vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q       <= '0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else if (clear) begin
            sr_q       <= '0;
            pend_vld_q <= 1'b0;
        end else if (start) begin
            sr_q       <= start_data;
            pend_vld_q <= 1'b0;
        end else if (adv && reload) begin
            sr_q       <= wr ? wr_data : (pend_vld_q ? pend_q : '0);
            pend_vld_q <= 1'b0;
        end else begin
            if (adv) sr_q <= {sr_q[DATA_W-2:0], 1'b0};
            if (wr) begin
                pend_q     <= wr_data;
                pend_vld_q <= 1'b1;
            end
        end
    end

    assign tx_bit = sr_q[DATA_W-1];
endmodule

// File: rtl/spi_hd_slave.sv
module spi_hd_slave
    import spi_hd_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_first,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_data,
    output logic              tx_load,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata
);
    localparam int               CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

    logic [2:0]       pins_s;
    logic             sck_s, cs_s, si_s;
    logic             sck_p, cs_p;
    logic             sck_rise, sck_fall, cs_rise;
    spi_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             first_q, armed_q;
    logic             tx_bit;
    logic             rx_shift, tx_start, tx_adv;

    spi_hd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in({sck, cs_n, si}), .sync_out(pins_s)
    );
    assign {sck_s, cs_s, si_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p <= 1'b0;
            cs_p  <= 1'b1;
        end else begin
            sck_p <= sck_s;
            cs_p  <= cs_s;
        end
    end

    assign sck_rise = sck_s & ~sck_p;
    assign sck_fall = ~sck_s & sck_p;
    assign cs_rise  = cs_s & ~cs_p;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!cs_s) state_d = ST_RECV;
            ST_RECV: begin
                if (cs_s)                                        state_d = ST_IDLE;
                else if (rd_req && cnt_q == '0 && !sck_rise)     state_d = ST_SEND;
            end
            ST_SEND: if (cs_s) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign rx_shift = (state_q == ST_RECV) && !cs_s && sck_rise;
    assign tx_start = (state_q == ST_RECV) && (state_d == ST_SEND);
    assign tx_adv   = (state_q == ST_SEND) && !cs_s && sck_fall && armed_q;

    // bit counter, first-byte flag, falling-edge arm
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            first_q <= 1'b1;
            armed_q <= 1'b0;
        end else if (state_q == ST_IDLE || cs_s) begin
            cnt_q   <= '0;
            first_q <= 1'b1;
            armed_q <= 1'b0;
        end else begin
            if (sck_rise) begin
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                if (state_q == ST_RECV && cnt_q == LAST) first_q <= 1'b0;
                if (state_q == ST_SEND) armed_q <= 1'b1;
            end
            if (tx_adv) armed_q <= 1'b0;
        end
    end

    spi_hd_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .shift_en(rx_shift), .bit_in(si_s),
        .last_bit(cnt_q == LAST), .first_in(first_q),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_first(rx_first)
    );

    spi_hd_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .clear(state_q == ST_IDLE),
        .start(tx_start), .start_data(rd_data),
        .wr(tx_wr && state_q == ST_SEND), .wr_data(tx_wdata),
        .adv(tx_adv), .reload(cnt_q == '0), .tx_bit(tx_bit)
    );

    // registered output: next-byte request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_load <= 1'b0;
        else        tx_load <= (state_q == ST_SEND) && !cs_s && sck_rise && (cnt_q == LAST);
    end

    // state-decoded outputs
    always_comb begin
        so_oe = (state_q == ST_SEND);
        so    = so_oe & tx_bit;
    end
endmodule

// File: rtl/spi_hd_slave_chk.sv
module spi_hd_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic rx_first,
    input logic tx_load,
    input logic so,
    input logic so_oe,
    input logic cs_rise,
    input logic sck_fall
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R4
    AST_FIRST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_first |-> rx_valid); // R2
    AST_NO_RX_WHILE_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> !rx_valid); // R9
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load); // R7
    AST_LOAD_IN_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> so_oe); // R7
    AST_SO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && !$past(sck_fall)) |-> $stable(so)); // R6
    AST_OE_DROP_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !so_oe); // R10
endmodule

bind spi_hd_slave spi_hd_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
    .tx_load(tx_load), .so(so), .so_oe(so_oe), .cs_rise(cs_rise), .sck_fall(sck_fall)
);

// File: tb/spi_hd_slave_tb.sv
`timescale 1ns/1ps
module spi_hd_slave_tb;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic       so, so_oe, rx_valid, rx_first, tx_load;
    logic [7:0] rx_data;
    logic       rd_req = 1'b0, tx_wr = 1'b0;
    logic [7:0] rd_data = '0, tx_wdata = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [7:0]  mosi [16];
    logic [15:0] starve = '0;
    logic [7:0]  salt = '0;
    logic [7:0]  ev_data [64];
    bit          ev_first [64];
    int ev_n = 0, n_load = 0, dbl = 0;
    bit inject = 0;
    bit prev_v = 0;

    always #2.5 clk = ~clk;

    spi_hd_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_first(rx_first), .rd_req(rd_req), .rd_data(rd_data),
        .tx_load(tx_load), .tx_wr(tx_wr), .tx_wdata(tx_wdata)
    );

    function automatic logic [7:0] resp(int k);
        return 8'(k * 37 + 90) ^ salt;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // on-chip decoder model: monitors strobes and answers requests
    initial begin
        forever begin
            @(negedge clk);
            rd_req = 1'b0;
            tx_wr  = 1'b0;
            if (rx_valid && prev_v) dbl++;
            prev_v = rx_valid;
            if (rx_valid && ev_n < 64) begin
                ev_data[ev_n]  = rx_data;
                ev_first[ev_n] = rx_first;
                ev_n++;
            end
            if (inject) begin
                rd_req = 1'b1; rd_data = 8'hFF; inject = 0;
            end else if (rx_valid && rx_first && rx_data[7]) begin
                rd_req = 1'b1; rd_data = resp(0);
            end
            if (tx_load) begin
                n_load++;
                if (!starve[n_load[3:0]]) begin
                    tx_wr = 1'b1; tx_wdata = resp(n_load);
                end
            end
        end
    end

    task automatic xfer(int nb, int extra);
        logic [7:0] miso [16];
        bit is_rd;
        int oe_bad, tot;
        is_rd  = (nb > 0) && mosi[0][7];
        ev_n   = 0;
        n_load = 0;
        oe_bad = 0;
        tot    = nb + ((extra > 0) ? 1 : 0);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < tot; i++) begin
            int bits = (i < nb) ? 8 : extra;
            for (int b = 0; b < bits; b++) begin
                si = mosi[i][7-b];
                repeat (HALF) @(negedge clk);
                if (is_rd && i == 1 && b == 0)
                    chk(so_oe && so == resp(0)[7], "R5 first MSB before first edge",
                        {so_oe, so}, {1'b1, resp(0)[7]});
                if (!is_rd && so_oe) oe_bad++;
                miso[i][7-b] = so;
                sck = 1'b1;
                repeat (HALF) @(negedge clk);
                sck = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(so_oe == 1'b0, "R10 oe dropped after select rises", so_oe, 0);
        repeat (4) @(negedge clk);
        if (is_rd) begin
            chk(ev_n == 1 && ev_data[0] == mosi[0] && ev_first[0],
                "R9 only command byte strobed", ev_n, 1);
            chk(n_load == nb - 1, "R7 load strobe per read byte", n_load, nb - 1);
            for (int i = 1; i < nb; i++) begin
                logic [7:0] e;
                e = (i == 1) ? resp(0) : (starve[i-1] ? 8'h00 : resp(i-1));
                if (i > 1 && starve[i-1]) chk(miso[i] == e, "R8 unsupplied byte is zero", miso[i], e);
                else                      chk(miso[i] == e, "R6 read byte", miso[i], e);
            end
        end else begin
            chk(ev_n == nb, "R3 strobe count (partial dropped)", ev_n, nb);
            for (int i = 0; i < nb && i < ev_n; i++) begin
                chk(ev_data[i] == mosi[i], "R1 received byte", ev_data[i], mosi[i]);
                chk(ev_first[i] == (i == 0), "R2 first flag", ev_first[i], i == 0);
            end
            chk(oe_bad == 0, "R10 oe low in write transaction", oe_bad, 0);
            chk(n_load == 0, "R7 no load outside read", n_load, 0);
        end
        chk(dbl == 0, "R4 single-cycle strobe", dbl, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0123));
        repeat (4) @(negedge clk);
        chk(so_oe == 0 && rx_valid == 0 && tx_load == 0, "R10 reset state",
            {so_oe, rx_valid, tx_load}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // directed: three write bytes
        mosi[0] = 8'h12; mosi[1] = 8'hA5; mosi[2] = 8'h3C;
        xfer(3, 0);
        // directed: partial byte dropped, next window aligned
        mosi[0] = 8'h01; mosi[1] = 8'hFE; mosi[2] = 8'hFF;
        xfer(2, 5);
        mosi[0] = 8'h55; mosi[1] = 8'h80;
        xfer(2, 0);
        // directed: only a partial byte
        mosi[0] = 8'h7F;
        xfer(0, 6);
        // directed: read mode request with select high is ignored
        inject = 1;
        repeat (6) @(negedge clk);
        chk(so_oe == 0, "R5 request ignored while select high", so_oe, 0);
        // directed: read, second byte starved
        salt = 8'h33; starve = 16'h0002;
        mosi[0] = 8'h81; mosi[1] = 8'hFF; mosi[2] = 8'h00; mosi[3] = 8'hAA;
        xfer(4, 0);
        // random mix
        for (int t = 0; t < 40; t++) begin
            int nb, ex;
            nb = 1 + int'($urandom_range(0, 5));
            ex = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 7)) : 0;
            salt = 8'($urandom);
            starve = 16'($urandom) & 16'hFFFE;
            for (int i = 0; i < 8; i++) mosi[i] = 8'($urandom);
            xfer(nb, ex);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule